// File: doc/BRIEF.md
# Dual-Timebase Capture/Compare Array

The block holds two free-running 16-bit timebases and an array of channel registers that watch them. Each timebase counts on a selectable clock: one of four power-of-two taps of the system clock (the finest is every 8 cycles), a single-cycle overflow strobe from a neighbouring timer module, or, for timebase 0 only, rising edges on an external count pin. When a timebase steps past all-ones it reloads from its own reload register and starts a new period.

Every channel is bound to one timebase and one pin. In capture mode, a chosen transition on the pin copies the bound timebase into the channel register. In compare mode, the channel watches for the timebase stepping onto its stored value. Depending on the mode, it then raises its request flag, toggles the pin, fires once per period, or sets the pin until the period ends. A double mode lets a lower-half channel and its upper-half partner (index + NCH/2) toggle one shared pin. Software sets up timers and channels through a write-only port that is valid/ready. `wr_ready` is held high, so a write is taken on every clock edge where `wr_valid` is high and nothing is ever back-pressured.

Top module: `capcom_array`

## Requirements
- R1: After reset all request flags, pin outputs, pin enables, channel values and timer values are zero. Every channel is off and both timers are stopped.
- R2: `wr_ready` is always 1, and a write takes effect at the edge where `wr_valid` is high. Address map (NCH=16): 0..15 write a channel value. 16..31 write a channel config, with mode in [2:0], timer select in [3] and capture edge in [5:4]. 32/33 write the timer 0 count/reload, and 34/35 the timer 1 count/reload. 36/37 write the timer 0/1 control, with run in [0] and source in [3:1]. 38 is a write-1-to-clear mask for the flags.
- R3: A running timer steps by one on each tick. Source 0..3 ticks once every 8, 16, 32 or 64 clocks of a free-running prescaler that starts at reset. Source 4 ticks on each cycle with `ext_ovf_strobe` high. Sources 6 and 7 never tick. A count write wins over a tick in the same edge.
- R4: A tick taken at 0xFFFF loads the reload value in force before that edge, and this starts a new period.
- R5: Source 5 on timer 0 ticks on each rising edge of `t0_count_in`, seen after a two-flop synchroniser. On timer 1, source 5 never ticks.
- R6: Capture (mode 1) copies the bound timer into the channel value and sets the flag for a synchronised pin rise (edge bit 0), fall (edge bit 1) or either. Edge code 00 captures nothing. A capture wins over a value write in the same edge.
- R7: Mode 2 sets the flag on every match, where a match is the timer stepping onto the channel value. The flag shows the match one edge after the timer step.
- R8: Mode 3 toggles the pin and sets the flag on every match.
- R9: Mode 4 sets the flag on the first match of each period only. Overflow and config writes re-arm it.
- R10: Mode 5 drives the pin to 1 and sets the flag on the first match of a period, and drives the pin to 0 on overflow. A match in the overflow cycle wins.
- R11: Mode 6 on channel i < NCH/2 toggles pin i on its own match or a match of channel i+NCH/2 in any compare mode. Only its own match sets its flag.
- R12: A flag clears when written 1 through the clear address. A set in the same edge wins.
- R13: `cc_pin_oe[i]` is 1 exactly when channel i is in modes 2..6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | AW (6) | Register address |
| wr_data | input | TW (16) | Write data |
| ext_ovf_strobe | input | 1 | Overflow strobe from another timer module |
| t0_count_in | input | 1 | External count input for timer 0 |
| cc_pin_in | input | NCH | Channel pin inputs (capture) |
| cc_pin_out | output | NCH | Channel pin outputs (compare) |
| cc_pin_oe | output | NCH | Channel pin output enables |
| irq_flag | output | NCH | Per-channel request flags |
| chan_val | output | NCH*TW | Channel registers, channel i at [i*TW +: TW] |
| tmr_val | output | 2*TW | Timer 0 at [TW-1:0], timer 1 above |

## Verification
The bench builds the default parameters: NCH=16, TW=16 and four prescaler taps. This puts the double-mode pairs (channel 4 with 12) and the full flag-clear mask within reach. Reload values near 0xFFFF make a period only tens of ticks long. With the strobe source ticking on most cycles, overflows arrive many times per run, so reload, re-arming, the mode-5 pin clear and a match landing on the reload value are all hit repeatedly. Stepping timer 1 through every prescaler tap and timer 0 through the external count pin covers each clock source.

// File: rtl/capcom_pkg.sv
package capcom_pkg;
  typedef enum logic [2:0] {
    M_OFF    = 3'd0,
    M_CAPT   = 3'd1,
    M_EVERY  = 3'd2,
    M_TOGGLE = 3'd3,
    M_ONCE   = 3'd4,
    M_SETCLR = 3'd5,
    M_DOUBLE = 3'd6,
    M_RSVD   = 3'd7
  } ch_mode_e;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic       tsel;
    ch_mode_e   mode;
  } ch_cfg_t;

  localparam int CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/capcom_prescaler.sv
module capcom_prescaler #(
  parameter int NTAP     = 4,
  parameter int BASE_LOG = 3,
  parameter int PW       = BASE_LOG + NTAP - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NTAP-1:0] tap
);
  logic [PW-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q + PW'(1);
  end

  // tap k fires once every 2^(BASE_LOG+k) cycles
  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap[k] = &q[BASE_LOG-1+k:0];
  end
endmodule

// File: rtl/capcom_sync.sv
module capcom_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] now,
  output logic [W-1:0] was
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      now  <= '0;
      was  <= '0;
    end else begin
      meta <= din;
      now  <= meta;
      was  <= now;
    end
  end
endmodule

// File: rtl/capcom_timer.sv
module capcom_timer #(
  parameter int TW      = 16,
  parameter int NTAP    = 4,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTAP-1:0] tap,
  input  logic            strobe,
  input  logic            ext_rise,
  input  logic            ctl_wr,
  input  logic            cnt_wr,
  input  logic            rel_wr,
  input  logic [TW-1:0]   wdata,
  output logic [TW-1:0]   cnt,
  output logic [TW-1:0]   rel,
  output logic            adv,
  output logic            ovf
);
  localparam logic [2:0] SRC_STROBE = 3'(NTAP);
  localparam logic [2:0] SRC_EXT    = 3'(NTAP + 1);

  logic       run_q;
  logic [2:0] src_q;
  logic       tick;
  logic       wrap;

  always_comb begin
    tick = 1'b0;
    for (int k = 0; k < NTAP; k++) begin
      if (src_q == 3'(k)) tick = tap[k];
    end
    if (src_q == SRC_STROBE) tick = strobe;
    if (src_q == SRC_EXT)    tick = ext_rise & HAS_EXT;
    tick = tick & run_q;
  end

  assign wrap = (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      src_q <= '0;
      cnt   <= '0;
      rel   <= '0;
      adv   <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        run_q <= wdata[0];
        src_q <= wdata[3:1];
      end
      if (rel_wr) rel <= wdata;
      adv <= 1'b0;
      ovf <= 1'b0;
      if (cnt_wr) begin
        cnt <= wdata;
      end else if (tick) begin
        adv <= 1'b1;
        if (wrap) begin
          cnt <= rel;
          ovf <= 1'b1;
        end else begin
          cnt <= cnt + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/capcom_channel.sv
module capcom_channel
  import capcom_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          val_wr,
  input  logic [TW-1:0] wdata,
  input  logic [TW-1:0] cnt0,
  input  logic [TW-1:0] cnt1,
  input  logic          adv0,
  input  logic          adv1,
  input  logic          ovf0,
  input  logic          ovf1,
  input  logic          pin_rise,
  input  logic          pin_fall,
  input  logic          partner_hit,
  input  logic          flag_clr,
  output logic [TW-1:0] val,
  output logic          hit,
  output logic          flag,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          set_ev,
  output logic          tog_ev
);
  ch_cfg_t       cfg_q;
  logic          armed_q;
  logic [TW-1:0] cnt_s;
  logic          adv_s, ovf_s;
  logic          is_cmp, one_shot, armed_eff, once, cap;

  assign cnt_s = cfg_q.tsel ? cnt1 : cnt0;
  assign adv_s = cfg_q.tsel ? adv1 : adv0;
  assign ovf_s = cfg_q.tsel ? ovf1 : ovf0;

  always_comb begin
    is_cmp   = cfg_q.mode inside {M_EVERY, M_TOGGLE, M_ONCE, M_SETCLR, M_DOUBLE};
    one_shot = cfg_q.mode inside {M_ONCE, M_SETCLR};
  end

  assign hit       = is_cmp & adv_s & (cnt_s == val);
  assign armed_eff = armed_q | ovf_s;
  assign once      = hit & armed_eff;
  assign cap       = (cfg_q.mode == M_CAPT) &
                     ((cfg_q.edge_sel[0] & pin_rise) | (cfg_q.edge_sel[1] & pin_fall));
  assign pin_oe    = is_cmp;

  always_comb begin
    unique case (cfg_q.mode)
      M_CAPT:                      set_ev = cap;
      M_EVERY, M_TOGGLE, M_DOUBLE: set_ev = hit;
      M_ONCE, M_SETCLR:            set_ev = once;
      default:                     set_ev = 1'b0;
    endcase
    tog_ev = ((cfg_q.mode == M_TOGGLE) & hit) |
             ((cfg_q.mode == M_DOUBLE) & (hit | partner_hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '{edge_sel: 2'b00, tsel: 1'b0, mode: M_OFF};
      armed_q <= 1'b1;
      val     <= '0;
      flag    <= 1'b0;
      pin_out <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= ch_cfg_t'(wdata[CFG_W-1:0]);

      if (cfg_wr)                armed_q <= 1'b1;
      else if (one_shot && once) armed_q <= 1'b0;
      else                       armed_q <= armed_eff;

      if (cap)         val <= cnt_s;
      else if (val_wr) val <= wdata;

      flag <= set_ev | (flag & ~flag_clr);

      if (tog_ev)                                   pin_out <= ~pin_out;
      else if ((cfg_q.mode == M_SETCLR) && once)    pin_out <= 1'b1;
      else if ((cfg_q.mode == M_SETCLR) && ovf_s)   pin_out <= 1'b0;
    end
  end
endmodule

// File: rtl/capcom_array.sv
module capcom_array
  import capcom_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int TW   = 16,
  parameter int NTAP = 4,
  parameter int AW   = $clog2(2 * NCH + 7)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_addr,
  input  logic [TW-1:0]     wr_data,
  input  logic              ext_ovf_strobe,
  input  logic              t0_count_in,
  input  logic [NCH-1:0]    cc_pin_in,
  output logic [NCH-1:0]    cc_pin_out,
  output logic [NCH-1:0]    cc_pin_oe,
  output logic [NCH-1:0]    irq_flag,
  output logic [NCH*TW-1:0] chan_val,
  output logic [2*TW-1:0]   tmr_val
);
  localparam int TMR_BASE = 2 * NCH;
  localparam int CTL_BASE = 2 * NCH + 4;
  localparam logic [AW-1:0] A_CLR = AW'(2 * NCH + 6);
  localparam int HALF = NCH / 2;

  logic [NTAP-1:0] taps;
  logic [NCH-1:0]  pin_now, pin_was, pin_rise, pin_fall;
  logic            cin_now, cin_was, cin_rise;
  logic [TW-1:0]   tcnt [2];
  logic [TW-1:0]   trel [2];
  logic            tadv [2];
  logic            tovf [2];
  logic [NCH-1:0]  hit_vec, set_vec, tog_vec, clr_mask;
  logic            t0_ovf;
  logic [TW-1:0]   t0_cnt, t0_rel;

  assign wr_ready = 1'b1;
  assign clr_mask = (wr_valid && wr_addr == A_CLR) ? NCH'(wr_data) : '0;

  capcom_prescaler #(.NTAP(NTAP)) u_presc (
    .clk(clk), .rst_n(rst_n), .tap(taps)
  );

  capcom_sync #(.W(NCH)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .din(cc_pin_in), .now(pin_now), .was(pin_was)
  );
  capcom_sync #(.W(1)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .din(t0_count_in), .now(cin_now), .was(cin_was)
  );

  assign pin_rise = pin_now & ~pin_was;
  assign pin_fall = ~pin_now & pin_was;
  assign cin_rise = cin_now & ~cin_was;

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    capcom_timer #(.TW(TW), .NTAP(NTAP), .HAS_EXT(t == 0)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tap     (taps),
      .strobe  (ext_ovf_strobe),
      .ext_rise(cin_rise),
      .ctl_wr  (wr_valid && wr_addr == AW'(CTL_BASE + t)),
      .cnt_wr  (wr_valid && wr_addr == AW'(TMR_BASE + 2 * t)),
      .rel_wr  (wr_valid && wr_addr == AW'(TMR_BASE + 2 * t + 1)),
      .wdata   (wr_data),
      .cnt     (tcnt[t]),
      .rel     (trel[t]),
      .adv     (tadv[t]),
      .ovf     (tovf[t])
    );
  end

  assign tmr_val = {tcnt[1], tcnt[0]};
  assign t0_ovf  = tovf[0];
  assign t0_cnt  = tcnt[0];
  assign t0_rel  = trel[0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic partner;
    if (i < HALF) begin : g_pair
      assign partner = hit_vec[i + HALF];
    end else begin : g_solo
      assign partner = 1'b0;
    end

    capcom_channel #(.TW(TW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (wr_valid && wr_addr == AW'(NCH + i)),
      .val_wr     (wr_valid && wr_addr == AW'(i)),
      .wdata      (wr_data),
      .cnt0       (tcnt[0]),
      .cnt1       (tcnt[1]),
      .adv0       (tadv[0]),
      .adv1       (tadv[1]),
      .ovf0       (tovf[0]),
      .ovf1       (tovf[1]),
      .pin_rise   (pin_rise[i]),
      .pin_fall   (pin_fall[i]),
      .partner_hit(partner),
      .flag_clr   (clr_mask[i]),
      .val        (chan_val[i*TW +: TW]),
      .hit        (hit_vec[i]),
      .flag       (irq_flag[i]),
      .pin_out    (cc_pin_out[i]),
      .pin_oe     (cc_pin_oe[i]),
      .set_ev     (set_vec[i]),
      .tog_ev     (tog_vec[i])
    );
  end
endmodule

// File: rtl/capcom_checker.sv
module capcom_checker #(
  parameter int NCH = 16,
  parameter int TW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_valid,
  input logic [NCH-1:0] irq_flag,
  input logic [NCH-1:0] cc_pin_out,
  input logic [NCH-1:0] cc_pin_oe,
  input logic [NCH-1:0] set_vec,
  input logic [NCH-1:0] tog_vec,
  input logic           t0_ovf,
  input logic [TW-1:0]  t0_cnt,
  input logic [TW-1:0]  t0_rel
);
  // R4
  reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t0_ovf |-> t0_cnt == $past(t0_rel));

  // R13
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(cc_pin_oe));

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R12
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> irq_flag[i]);

    // R8
    pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tog_vec[i] |=> cc_pin_out[i] != $past(cc_pin_out[i]));
  end
endmodule

bind capcom_array capcom_checker #(.NCH(NCH), .TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .irq_flag  (irq_flag),
  .cc_pin_out(cc_pin_out),
  .cc_pin_oe (cc_pin_oe),
  .set_vec   (set_vec),
  .tog_vec   (tog_vec),
  .t0_ovf    (t0_ovf),
  .t0_cnt    (t0_cnt),
  .t0_rel    (t0_rel)
);

// File: tb/tb_capcom_array.sv
module tb_capcom_array;
  localparam int NCH = 16;
  localparam int TW  = 16;
  localparam int AW  = $clog2(2 * NCH + 7);
  localparam int A_CLR = 2 * NCH + 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [AW-1:0]     wr_addr = '0;
  logic [TW-1:0]     wr_data = '0;
  logic              ext_ovf_strobe = 1'b0;
  logic              t0_count_in = 1'b0;
  logic [NCH-1:0]    cc_pin_in = '0;
  logic [NCH-1:0]    cc_pin_out, cc_pin_oe, irq_flag;
  logic [NCH*TW-1:0] chan_val;
  logic [2*TW-1:0]   tmr_val;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit rnd_on = 1'b0;

  always #5 clk = ~clk;

  capcom_array #(.NCH(NCH), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ext_ovf_strobe(ext_ovf_strobe),
    .t0_count_in(t0_count_in), .cc_pin_in(cc_pin_in), .cc_pin_out(cc_pin_out),
    .cc_pin_oe(cc_pin_oe), .irq_flag(irq_flag), .chan_val(chan_val),
    .tmr_val(tmr_val)
  );

  // ---------------- behavioural reference ----------------
  int            p;
  logic [TW-1:0] m_cnt [2];
  logic [TW-1:0] m_rel [2];
  bit            m_run [2];
  int            m_src [2];
  bit            m_adv [2];
  bit            m_ovf [2];
  bit [NCH-1:0]  s1, s2, s3;
  bit            c1, c2, c3;
  logic [TW-1:0] m_val [NCH];
  int            m_mode [NCH];
  bit            m_tsel [NCH];
  bit [1:0]      m_edge [NCH];
  bit            m_armed [NCH];
  bit            m_flag [NCH];
  bit            m_pin [NCH];

  task automatic model_reset();
    p = 0;
    s1 = '0; s2 = '0; s3 = '0; c1 = 0; c2 = 0; c3 = 0;
    for (int t = 0; t < 2; t++) begin
      m_cnt[t] = '0; m_rel[t] = '0; m_run[t] = 0; m_src[t] = 0;
      m_adv[t] = 0; m_ovf[t] = 0;
    end
    for (int i = 0; i < NCH; i++) begin
      m_val[i] = '0; m_mode[i] = 0; m_tsel[i] = 0; m_edge[i] = 2'b00;
      m_armed[i] = 1; m_flag[i] = 0; m_pin[i] = 0;
    end
  endtask

  task automatic model_step();
    bit [NCH-1:0] hit;
    bit [NCH-1:0] rise, fall;
    bit           tick [2];
    int           a;
    a = int'(wr_addr);
    rise = s2 & ~s3;
    fall = ~s2 & s3;
    for (int t = 0; t < 2; t++) begin
      tick[t] = 0;
      if (m_src[t] < 4)       tick[t] = ((p + 1) % (8 << m_src[t])) == 0;
      else if (m_src[t] == 4) tick[t] = ext_ovf_strobe;
      else if (m_src[t] == 5) tick[t] = (t == 0) && c2 && !c3;
      tick[t] = tick[t] && m_run[t];
    end
    for (int i = 0; i < NCH; i++) begin
      int ts;
      ts = m_tsel[i];
      hit[i] = (m_mode[i] >= 2 && m_mode[i] <= 6) && m_adv[ts] && (m_cnt[ts] == m_val[i]);
    end
    for (int i = 0; i < NCH; i++) begin
      int ts, md;
      bit ov, armd, once, cap, setv, tog, partner;
      ts = m_tsel[i]; md = m_mode[i]; ov = m_ovf[ts];
      armd = m_armed[i] | ov;
      once = hit[i] & armd;
      cap = (md == 1) && ((m_edge[i][0] && rise[i]) || (m_edge[i][1] && fall[i]));
      if (md == 1)                          setv = cap;
      else if (md == 2 || md == 3 || md == 6) setv = hit[i];
      else if (md == 4 || md == 5)          setv = once;
      else                                  setv = 0;
      partner = (i < NCH / 2) ? hit[i + NCH / 2] : 1'b0;
      tog = (md == 3 && hit[i]) || (md == 6 && (hit[i] || partner));
      if (tog)                 m_pin[i] = ~m_pin[i];
      else if (md == 5 && once) m_pin[i] = 1;
      else if (md == 5 && ov)   m_pin[i] = 0;
      if (wr_valid && a == NCH + i)          m_armed[i] = 1;
      else if ((md == 4 || md == 5) && once) m_armed[i] = 0;
      else                                   m_armed[i] = armd;
      if (cap)                        m_val[i] = m_cnt[ts];
      else if (wr_valid && a == i)    m_val[i] = wr_data;
      m_flag[i] = setv || (m_flag[i] && !(wr_valid && a == A_CLR && wr_data[i]));
      if (wr_valid && a == NCH + i) begin
        m_mode[i] = int'(wr_data[2:0]);
        m_tsel[i] = wr_data[3];
        m_edge[i] = wr_data[5:4];
      end
    end
    for (int t = 0; t < 2; t++) begin
      m_adv[t] = 0; m_ovf[t] = 0;
      if (wr_valid && a == 2 * NCH + 2 * t) begin
        m_cnt[t] = wr_data;
      end else if (tick[t]) begin
        m_adv[t] = 1;
        if (m_cnt[t] == 16'hFFFF) begin
          m_cnt[t] = m_rel[t];
          m_ovf[t] = 1;
        end else begin
          m_cnt[t] = m_cnt[t] + 1'b1;
        end
      end
      if (wr_valid && a == 2 * NCH + 2 * t + 1) m_rel[t] = wr_data;
      if (wr_valid && a == 2 * NCH + 4 + t) begin
        m_run[t] = wr_data[0];
        m_src[t] = int'(wr_data[3:1]);
      end
    end
    s3 = s2; s2 = s1; s1 = cc_pin_in;
    c3 = c2; c2 = c1; c1 = t0_count_in;
    p++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string mtag(input int md);
    case (md)
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      5: return "R10";
      6: return "R11";
      default: return "R12";
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < NCH; i++) begin
        chk(mtag(m_mode[i]), $sformatf("flag[%0d]", i), irq_flag[i], m_flag[i]);
        chk(mtag(m_mode[i]), $sformatf("pin[%0d]", i), cc_pin_out[i], m_pin[i]);
        chk("R13", $sformatf("oe[%0d]", i), cc_pin_oe[i], (m_mode[i] >= 2 && m_mode[i] <= 6));
        chk((m_mode[i] == 1) ? "R6" : "R2", $sformatf("val[%0d]", i),
            chan_val[i*TW +: TW], m_val[i]);
      end
      for (int t = 0; t < 2; t++) begin
        string tg;
        if (m_src[t] == 5)  tg = "R5";
        else if (m_ovf[t])  tg = "R4";
        else                tg = "R3";
        chk(tg, $sformatf("timer%0d", t), tmr_val[t*TW +: TW], m_cnt[t]);
      end
    end
  end

  // ---------------- stimulus ----------------
  always @(negedge clk) begin
    if (rnd_on) begin
      cc_pin_in      = cc_pin_in ^ NCH'($urandom & $urandom & $urandom);
      ext_ovf_strobe = ($urandom_range(3) != 0);
      t0_count_in    = $urandom_range(1) != 0;
    end
  end

  task automatic wr(input int a, input int d);
    wr_valid = 1'b1;
    wr_addr  = AW'(a);
    wr_data  = TW'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic int cfgw(input int md, input int ts, input int ed);
    return md | (ts << 3) | (ed << 4);
  endfunction

  task automatic run_rand(input int n);
    for (int k = 0; k < n; k++) begin
      if ($urandom_range(39) == 0) begin
        wr_valid = 1'b1; wr_addr = AW'(A_CLR); wr_data = TW'($urandom);
      end else if ($urandom_range(59) == 0) begin
        wr_valid = 1'b1; wr_addr = AW'(5 + $urandom_range(2)); wr_data = TW'($urandom);
      end else begin
        wr_valid = 1'b0;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  initial begin
    logic [TW-1:0] t1_snap;
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    chk("R1", "irq_flag", irq_flag, 0);
    chk("R1", "pin_out", cc_pin_out, 0);
    chk("R1", "pin_oe", cc_pin_oe, 0);
    chk("R1", "chan_val", chan_val, 0);
    chk("R1", "tmr_val", tmr_val, 0);
    // R2: never back-pressured
    chk("R2", "wr_ready", wr_ready, 1);
    cmp_on = 1'b1;

    // timers: T0 on the strobe, T1 on the /8 tap
    wr(2 * NCH + 1, 'hFFF0); wr(2 * NCH, 'hFFF0); wr(2 * NCH + 4, 1 | (4 << 1));
    wr(2 * NCH + 3, 'hFF00); wr(2 * NCH + 2, 'hFFF8); wr(2 * NCH + 5, 1 | (0 << 1));
    // channels
    wr(0, 'hFFF4);  wr(NCH + 0,  cfgw(2, 0, 0));
    wr(1, 'hFFF2);  wr(NCH + 1,  cfgw(3, 0, 0));
    wr(2, 'hFFF5);  wr(NCH + 2,  cfgw(4, 0, 0));
    wr(3, 'hFFF8);  wr(NCH + 3,  cfgw(5, 0, 0));
    wr(4, 'hFFF3);  wr(NCH + 4,  cfgw(6, 0, 0));
    wr(12, 'hFFFA); wr(NCH + 12, cfgw(2, 1, 0));
    wr(NCH + 5, cfgw(1, 1, 1));
    wr(NCH + 6, cfgw(1, 0, 2));
    wr(NCH + 7, cfgw(1, 0, 3));
    wr(NCH + 9, cfgw(1, 0, 0));
    wr(8, 'hFF02);  wr(NCH + 8,  cfgw(4, 1, 0));
    wr(10, 'hFFF0); wr(NCH + 10, cfgw(5, 0, 0));
    wr(11, 'hFFF6); wr(NCH + 11, cfgw(3, 0, 0));
    wr(13, 'hFF01); wr(NCH + 13, cfgw(5, 1, 0));
    wr(14, 'hFFF0); wr(NCH + 14, cfgw(4, 0, 0));
    wr(15, 'h1234); wr(NCH + 15, cfgw(7, 0, 0));
    chk("R2", "wr_ready", wr_ready, 1);

    rnd_on = 1'b1;
    run_rand(3000);

    // R5: T0 counts the external pin, T1 with source 5 must hold
    wr(2 * NCH + 4, 1 | (5 << 1));
    wr(2 * NCH + 5, 1 | (5 << 1));
    t1_snap = tmr_val[2*TW-1:TW];
    run_rand(1500);
    chk("R5", "timer1 held on source 5", tmr_val[2*TW-1:TW], t1_snap);

    // R3: other prescaler taps on T1
    wr(2 * NCH + 5, 1 | (1 << 1)); run_rand(2500);
    wr(2 * NCH + 5, 1 | (2 << 1)); run_rand(2500);
    wr(2 * NCH + 5, 1 | (3 << 1)); run_rand(1500);
    wr(2 * NCH + 4, 0 | (4 << 1)); run_rand(300);
    wr(2 * NCH + 4, 1 | (6 << 1)); run_rand(200);

    // R12: quiet everything, then clear all flags
    rnd_on = 1'b0;
    wr(2 * NCH + 4, 0); wr(2 * NCH + 5, 0);
    repeat (6) @(negedge clk);
    wr(A_CLR, 'hFFFF);
    chk("R12", "flags after clear-all", irq_flag, 0);

    cmp_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule